// File: doc/BRIEF.md
# SCSI Initiator Arbitration and Selection Sequencer

This block runs the two bus-acquisition steps of a parallel SCSI initiator. A host issues a one-cycle command strobe carrying a 4-bit opcode and an attention flag. An Arbitrate command waits for the bus to go free, claims it with BSY and the initiator's own ID bit, and decides the winner from the data lines. A Select command then puts both IDs on the data lines, asserts SEL (and ATN on request), drops BSY and waits for the target to raise BSY.

Every wait is a whole number of clock cycles set by a parameter. The bus lines are modelled as separate drive outputs and observed inputs. The observed inputs are the wired-OR of all devices, this one included. Each finished sequence raises command-done. A lost arbitration and a selection timeout each set their own exception flag and the exception interrupt.

Top module: `scsi_arbsel_seq`

## Requirements
- R1: After reset all bus drives (BSY, SEL, ATN, data) are low, and busy, command-done, both exception flags and the exception interrupt are low.
- R2: While idle, a strobe with opcode 4'h1 (Arbitrate) is accepted. At the next edge every line this block drives is released, busy rises, and command-done and all exception state are cleared.
- R3: While waiting for bus free, the bus is sampled every T_FREE cycles, counted from the accepting edge. The bus is free when both BSY and SEL are low. When it is free, the arbitration-start check follows T_FREE+T_SETTLE cycles later. Otherwise the wait repeats.
- R4: At the arbitration-start check, a bus that is not free makes the block release all lines and return to the bus-free wait after T_CLEAR cycles. A free bus makes it drive BSY and the data bit 1<<src_id, and the arbitration-end check follows T_ARB cycles later.
- R5: Arbitration is won when no data bit above bit src_id is set and SEL is low. On a win, SEL is asserted, BSY and the ID bit stay driven, command-done rises and busy falls.
- R6: On a lost arbitration every line is released, the arbitration-lost flag and the exception interrupt rise, command-done rises and busy falls.
- R7: While idle, opcode 4'h2 (Select) drives the data lines to (1<<dst_id)|(1<<src_id), asserts SEL, releases BSY and drives ATN equal to the strobe's attention flag. The end check follows T_SEL cycles later.
- R8: At the end of selection, if BSY is seen the block releases SEL and the data lines and keeps ATN. If BSY is not seen it releases every line and sets the selection-timeout flag and the exception interrupt. Both outcomes raise command-done and return to idle.
- R9: A strobe that arrives while busy is ignored. It changes neither the lines nor the timing of the sequence in progress.
- R10: While idle, any other opcode leaves the bus lines unchanged, clears the exception state and raises command-done at the next edge without going busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_atn | input | 1 | Attention request for Select |
| src_id | input | ID_W | Own bus ID |
| dst_id | input | ID_W | Target bus ID |
| bus_bsy_in | input | 1 | Observed BSY (wired-OR) |
| bus_sel_in | input | 1 | Observed SEL (wired-OR) |
| bus_data_in | input | 2**ID_W | Observed data lines (wired-OR) |
| bus_bsy_out | output | 1 | BSY drive |
| bus_sel_out | output | 1 | SEL drive |
| bus_atn_out | output | 1 | ATN drive |
| bus_data_out | output | 2**ID_W | Data line drives |
| busy | output | 1 | Sequence in progress |
| cmd_done | output | 1 | Last command finished |
| arb_lost | output | 1 | Arbitration lost flag |
| sel_timeout | output | 1 | Selection timeout flag |
| exc_irq | output | 1 | Exception interrupt |

## Verification
The hardest case to reach is the retry path. Here the bus is free at the sampling point but busy again at the arbitration-start check, one settle interval later. The stimulus raises the other device's BSY a fixed number of cycles after the strobe, so that it covers only the start check, and drops it before the next free sample. Lost arbitrations are produced the same way. The other device's higher ID bit or SEL is applied only after this block has started driving BSY, so that the bus-free checks still pass.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREE_WAIT,
    ST_ARB_START,
    ST_ARB_END,
    ST_SEL_END
  } seq_state_t;

  localparam logic [3:0] OP_ARBITRATE = 4'h1;
  localparam logic [3:0] OP_SELECT    = 4'h2;
endpackage

// File: rtl/scsi_seq_timer.sv
module scsi_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/scsi_arb_judge.sv
module scsi_arb_judge #(
  parameter int ID_W = 3,
  localparam int NL  = 1 << ID_W
) (
  input  logic [NL-1:0]   data_in,
  input  logic            sel_in,
  input  logic [ID_W-1:0] own_id,
  output logic            won
);
  logic [NL-1:0] above;

  generate
    for (genvar g = 0; g < NL; g++) begin : g_above
      assign above[g] = data_in[g] && (g > int'(own_id));
    end
  endgenerate

  assign won = !sel_in && (above == '0);
endmodule

// File: rtl/scsi_arbsel_seq.sv
module scsi_arbsel_seq
  import scsi_seq_pkg::*;
#(
  parameter int ID_W     = 3,
  parameter int T_SETTLE = 1,
  parameter int T_FREE   = 20,
  parameter int T_ARB    = 60,
  parameter int T_CLEAR  = 20,
  parameter int T_SEL    = 5000,
  localparam int NL      = 1 << ID_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic            cmd_atn,
  input  logic [ID_W-1:0] src_id,
  input  logic [ID_W-1:0] dst_id,
  input  logic            bus_bsy_in,
  input  logic            bus_sel_in,
  input  logic [NL-1:0]   bus_data_in,
  output logic            bus_bsy_out,
  output logic            bus_sel_out,
  output logic            bus_atn_out,
  output logic [NL-1:0]   bus_data_out,
  output logic            busy,
  output logic            cmd_done,
  output logic            arb_lost,
  output logic            sel_timeout,
  output logic            exc_irq
);
  localparam int T_FS  = T_FREE + T_SETTLE;
  localparam int M1    = (T_FS > T_ARB) ? T_FS : T_ARB;
  localparam int M2    = (T_CLEAR > T_SEL) ? T_CLEAR : T_SEL;
  localparam int T_MAX = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(T_MAX + 1);

  localparam logic [CW-1:0] LD_FREE  = CW'(T_FREE - 1);
  localparam logic [CW-1:0] LD_FS    = CW'(T_FS - 1);
  localparam logic [CW-1:0] LD_ARB   = CW'(T_ARB - 1);
  localparam logic [CW-1:0] LD_CLEAR = CW'(T_CLEAR - 1);
  localparam logic [CW-1:0] LD_SEL   = CW'(T_SEL - 1);

  initial begin
    assert (T_FREE >= 1 && T_ARB >= 1 && T_CLEAR >= 1 && T_SEL >= 1 && T_SETTLE >= 0)
      else $error("delay parameters must be at least one cycle");
  end

  seq_state_t      state_q, state_n;
  logic            bsy_n, sel_n, atn_n, done_n, lost_n, to_n, irq_n;
  logic [NL-1:0]   data_n;
  logic            tmr_load, tmr_exp, arb_won, bus_free;
  logic [CW-1:0]   tmr_val;

  scsi_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  scsi_arb_judge #(.ID_W(ID_W)) u_judge (
    .data_in (bus_data_in),
    .sel_in  (bus_sel_in),
    .own_id  (src_id),
    .won     (arb_won)
  );

  function automatic logic [NL-1:0] id_bit(input logic [ID_W-1:0] id);
    return NL'(1) << id;
  endfunction

  assign bus_free = !bus_bsy_in && !bus_sel_in;

  always_comb begin
    state_n  = state_q;
    bsy_n    = bus_bsy_out;
    sel_n    = bus_sel_out;
    atn_n    = bus_atn_out;
    data_n   = bus_data_out;
    done_n   = cmd_done;
    lost_n   = arb_lost;
    to_n     = sel_timeout;
    irq_n    = exc_irq;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          done_n = 1'b0;
          lost_n = 1'b0;
          to_n   = 1'b0;
          irq_n  = 1'b0;
          if (cmd_op == OP_ARBITRATE) begin
            {bsy_n, sel_n, atn_n} = 3'b000;
            data_n   = '0;
            state_n  = ST_FREE_WAIT;
            tmr_load = 1'b1;
            tmr_val  = LD_FREE;
          end else if (cmd_op == OP_SELECT) begin
            data_n   = id_bit(dst_id) | id_bit(src_id);
            sel_n    = 1'b1;
            bsy_n    = 1'b0;
            atn_n    = cmd_atn;
            state_n  = ST_SEL_END;
            tmr_load = 1'b1;
            tmr_val  = LD_SEL;
          end else begin
            done_n = 1'b1;
          end
        end
      end
      ST_FREE_WAIT: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (bus_free) begin
            state_n = ST_ARB_START;
            tmr_val = LD_FS;
          end else begin
            tmr_val = LD_FREE;
          end
        end
      end
      ST_ARB_START: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (bus_free) begin
            bsy_n   = 1'b1;
            data_n  = id_bit(src_id);
            state_n = ST_ARB_END;
            tmr_val = LD_ARB;
          end else begin
            {bsy_n, sel_n, atn_n} = 3'b000;
            data_n  = '0;
            state_n = ST_FREE_WAIT;
            tmr_val = LD_CLEAR;
          end
        end
      end
      ST_ARB_END: begin
        if (tmr_exp) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
          if (arb_won) begin
            sel_n = 1'b1;
          end else begin
            {bsy_n, sel_n, atn_n} = 3'b000;
            data_n = '0;
            lost_n = 1'b1;
            irq_n  = 1'b1;
          end
        end
      end
      ST_SEL_END: begin
        if (tmr_exp) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
          if (bus_bsy_in) begin
            sel_n  = 1'b0;
            data_n = '0;
          end else begin
            {bsy_n, sel_n, atn_n} = 3'b000;
            data_n = '0;
            to_n   = 1'b1;
            irq_n  = 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      bus_bsy_out  <= 1'b0;
      bus_sel_out  <= 1'b0;
      bus_atn_out  <= 1'b0;
      bus_data_out <= '0;
      busy         <= 1'b0;
      cmd_done     <= 1'b0;
      arb_lost     <= 1'b0;
      sel_timeout  <= 1'b0;
      exc_irq      <= 1'b0;
    end else begin
      state_q      <= state_n;
      bus_bsy_out  <= bsy_n;
      bus_sel_out  <= sel_n;
      bus_atn_out  <= atn_n;
      bus_data_out <= data_n;
      busy         <= (state_n != ST_IDLE);
      cmd_done     <= done_n;
      arb_lost     <= lost_n;
      sel_timeout  <= to_n;
      exc_irq      <= irq_n;
    end
  end

  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_done) |-> !busy);

  assert_ignore_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid && !tmr_exp) |=> ($stable(bus_data_out) && $stable(bus_atn_out)));

  assert_lost_releases_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> (!bus_bsy_out && !bus_sel_out && !bus_atn_out && bus_data_out == '0));

  assert_timeout_releases_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_timeout) |-> (!bus_sel_out && !bus_atn_out && bus_data_out == '0));

  assert_one_id_in_arb_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARB_END) |-> (bus_bsy_out && $countones(bus_data_out) == 1));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(arb_lost && sel_timeout));

  assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
    exc_irq |-> (arb_lost || sel_timeout));
endmodule

// File: tb/test_scsi_arbsel_seq.sv
module test_scsi_arbsel_seq;
  localparam int ID_W = 3, NL = 8;
  localparam int TS = 1, TF = 4, TA = 6, TC = 3, TSEL = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_atn = 1'b0;
  logic [3:0] cmd_op = 4'h0;
  logic [2:0] src_id = 3'd3, dst_id = 3'd1;
  logic o_bsy = 1'b0, o_sel = 1'b0;
  logic [7:0] o_data = 8'h00;
  logic bsy_out, sel_out, atn_out, busy, cmd_done, arb_lost, sel_timeout, exc_irq;
  logic [7:0] data_out;
  wire bsy_in = bsy_out | o_bsy;
  wire sel_in = sel_out | o_sel;
  wire [7:0] data_in = data_out | o_data;

  int checks = 0, errors = 0, cyc = 0, busy_start = 0, busy_len = -1;
  logic prev_busy = 1'b0;

  always #5 clk = ~clk;

  scsi_arbsel_seq #(.ID_W(ID_W), .T_SETTLE(TS), .T_FREE(TF), .T_ARB(TA),
                    .T_CLEAR(TC), .T_SEL(TSEL)) i_scsi_arbsel_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_atn(cmd_atn),
    .src_id(src_id), .dst_id(dst_id), .bus_bsy_in(bsy_in), .bus_sel_in(sel_in),
    .bus_data_in(data_in), .bus_bsy_out(bsy_out), .bus_sel_out(sel_out),
    .bus_atn_out(atn_out), .bus_data_out(data_out), .busy(busy), .cmd_done(cmd_done),
    .arb_lost(arb_lost), .sel_timeout(sel_timeout), .exc_irq(exc_irq));

  // behavioural reference: phase name plus absolute due cycle
  int m_phase = 0; // 0 idle, 1 free wait, 2 arb start, 3 arb end, 4 selection
  int m_due = 0;
  logic m_bsy = 0, m_sel = 0, m_atn = 0, m_done = 0, m_lost = 0, m_to = 0, m_irq = 0;
  logic [7:0] m_data = 0;

  function automatic bit wins(logic [7:0] d, logic s, int id);
    for (int i = id + 1; i < NL; i++) if (d[i]) return 0;
    return !s;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_phase <= 0; m_bsy <= 0; m_sel <= 0; m_atn <= 0; m_data <= 0;
      m_done <= 0; m_lost <= 0; m_to <= 0; m_irq <= 0;
    end else if (m_phase == 0) begin
      if (cmd_valid) begin
        m_lost <= 0; m_to <= 0; m_irq <= 0;
        if (cmd_op == 4'h1) begin
          m_bsy <= 0; m_sel <= 0; m_atn <= 0; m_data <= 0; m_done <= 0;
          m_phase <= 1; m_due <= cyc + TF;
        end else if (cmd_op == 4'h2) begin
          m_data <= (8'd1 << dst_id) | (8'd1 << src_id);
          m_sel <= 1; m_bsy <= 0; m_atn <= cmd_atn; m_done <= 0;
          m_phase <= 4; m_due <= cyc + TSEL;
        end else m_done <= 1;
      end
    end else if (cyc == m_due) begin
      case (m_phase)
        1: if (!(m_bsy | o_bsy) && !(m_sel | o_sel)) begin m_phase <= 2; m_due <= cyc + TF + TS; end
           else m_due <= cyc + TF;
        2: if (!(m_bsy | o_bsy) && !(m_sel | o_sel)) begin
             m_bsy <= 1; m_data <= 8'd1 << src_id; m_phase <= 3; m_due <= cyc + TA;
           end else begin
             m_bsy <= 0; m_sel <= 0; m_atn <= 0; m_data <= 0; m_phase <= 1; m_due <= cyc + TC;
           end
        3: begin
             m_done <= 1; m_phase <= 0;
             if (wins(m_data | o_data, m_sel | o_sel, int'(src_id))) m_sel <= 1;
             else begin m_bsy <= 0; m_sel <= 0; m_atn <= 0; m_data <= 0; m_lost <= 1; m_irq <= 1; end
           end
        default: begin
             m_done <= 1; m_phase <= 0;
             if (m_bsy | o_bsy) begin m_sel <= 0; m_data <= 0; end
             else begin m_bsy <= 0; m_sel <= 0; m_atn <= 0; m_data <= 0; m_to <= 1; m_irq <= 1; end
           end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (busy && !prev_busy) busy_start = cyc;
    if (!busy && prev_busy) busy_len = cyc - busy_start;
    prev_busy = busy;
    if (!rst) begin
      check(bsy_out == m_bsy, "R4 bsy", bsy_out, m_bsy);
      check(sel_out == m_sel, "R5 sel", sel_out, m_sel);
      check(atn_out == m_atn, "R7 atn", atn_out, m_atn);
      check(data_out == m_data, "R7 data", data_out, m_data);
      check(cmd_done == m_done, "R5 done", cmd_done, m_done);
      check(arb_lost == m_lost, "R6 lost", arb_lost, m_lost);
      check(sel_timeout == m_to, "R8 timeout", sel_timeout, m_to);
      check(exc_irq == m_irq, "R6 irq", exc_irq, m_irq);
      check(busy == (m_phase != 0), "R9 busy", busy, m_phase != 0);
    end
  end

  task automatic issue(input logic [3:0] op, input logic atn);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_atn = atn;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check({bsy_out, sel_out, atn_out, busy, cmd_done, arb_lost, sel_timeout, exc_irq} == 0 && data_out == 0,
          "R1 reset", {bsy_out, sel_out, atn_out, busy, cmd_done}, 0);

    // win on an idle bus
    issue(4'h1, 0);
    check(busy == 1 && bsy_out == 0, "R2 accept", {busy, bsy_out}, 2);
    wait_idle(); @(negedge clk);
    check(busy_len == TF + TF + TS + TA, "R3 win timing", busy_len, TF + TF + TS + TA);
    check(sel_out && bsy_out && data_out == 8'h08 && cmd_done, "R5 win", {sel_out, bsy_out, data_out}, 12'h308);

    // select with attention, target answers
    issue(4'h2, 1);
    check(data_out == 8'h0A && sel_out && !bsy_out && atn_out, "R7 select drive", data_out, 8'h0A);
    repeat (10) @(negedge clk); o_bsy = 1;
    wait_idle(); @(negedge clk);
    check(!sel_out && data_out == 0 && atn_out && cmd_done && !sel_timeout, "R8 answered", {sel_out, atn_out}, 1);
    check(busy_len == TSEL, "R7 select timing", busy_len, TSEL);

    // bus held busy by target: sampling repeats
    issue(4'h1, 0);
    check(!atn_out && data_out == 0, "R2 release", data_out, 0);
    repeat (3 * TF) @(negedge clk);
    check(busy && !bsy_out, "R3 waiting", {busy, bsy_out}, 2);
    o_bsy = 0;
    wait_idle(); @(negedge clk);
    check(sel_out && cmd_done, "R5 win after wait", sel_out, 1);

    // other opcode: no bus change, done at once
    issue(4'h5, 0);
    check(!busy && cmd_done && sel_out && bsy_out, "R10 noop", {busy, cmd_done, sel_out}, 3);

    // bus grabbed between free sample and start check: retry after clear delay
    issue(4'h1, 0);
    repeat (5) @(negedge clk); o_bsy = 1;
    repeat (5) @(negedge clk); o_bsy = 0;
    wait_idle(); @(negedge clk);
    check(busy_len == TF + (TF + TS) + TC + (TF + TS) + TA, "R4 retry timing", busy_len,
          TF + (TF + TS) + TC + (TF + TS) + TA);
    check(sel_out && !arb_lost, "R4 retry win", sel_out, 1);

    // lost to a higher ID
    issue(4'h1, 0);
    while (!bsy_out) @(negedge clk);
    o_data = 8'h40;
    wait_idle(); @(negedge clk);
    check(arb_lost && exc_irq && !bsy_out && !sel_out && data_out == 0 && cmd_done, "R6 lost id",
          {arb_lost, exc_irq, bsy_out}, 6);
    o_data = 0;

    // lower ID present does not block, then lost to foreign SEL
    issue(4'h1, 0);
    while (!bsy_out) @(negedge clk);
    o_data = 8'h04;
    wait_idle(); @(negedge clk);
    check(sel_out && !arb_lost, "R5 lower id", sel_out, 1);
    o_data = 0;
    issue(4'h1, 0);
    while (!bsy_out) @(negedge clk);
    o_sel = 1;
    wait_idle(); @(negedge clk);
    check(arb_lost && !sel_out, "R6 lost sel", arb_lost, 1);
    o_sel = 0;

    // selection timeout; a strobe mid-way is ignored
    issue(4'h2, 0);
    repeat (5) @(negedge clk);
    issue(4'h1, 0);
    check(busy && sel_out && data_out == 8'h0A, "R9 ignored", data_out, 8'h0A);
    wait_idle(); @(negedge clk);
    check(busy_len == TSEL, "R9 timing kept", busy_len, TSEL);
    check(sel_timeout && exc_irq && !sel_out && !atn_out && data_out == 0 && cmd_done, "R8 timeout",
          {sel_timeout, exc_irq, sel_out}, 6);

    issue(4'h7, 0);
    check(!sel_timeout && !exc_irq && cmd_done, "R10 clears", {sel_timeout, exc_irq}, 0);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule